// File: doc/BRIEF.md
# Serial Control Register Port

This block is the serial side door into a small bank of 8-bit control registers. An external host selects the port by pulling the active-low chip select low, then toggles a serial clock. The first byte of each transfer is an instruction. Its top bit chooses read or write, and its lower seven bits give a start address. Any number of data bytes follow. The address steps forward by one after each data byte, for as long as chip select stays low. Releasing chip select abandons any partial byte, and the next transfer starts again with an instruction.

Register 0 is the port's own configuration. One bit picks the bit order of every byte on the wire. Another bit routes read data either onto the shared bidirectional data line (3-wire use) or onto the dedicated output line (4-wire use). A third bit, when written as 1, clears all other registers and then clears itself. A synchronous hardware reset clears everything, register 0 included. The register contents are exported as one flat vector for the rest of the chip.

The serial pins are oversampled by the chip's system clock. Serial clock edges are detected inside the block, so all state lives in the single system clock domain. The bidirectional pin is presented as separate in, out and output-enable signals, and so is the high-impedance control of the dedicated output.

Top module: `spi_ctrl_port`

## Requirements
- R1: Input bits are taken on each rising serial clock edge. Read data changes only after a falling serial clock edge, and it holds steady through the following rising edge.
- R2: Taking `csn` high discards any partial byte. The first byte of the next transfer is always treated as an instruction.
- R3: In the instruction byte, bit 7 = 1 means read and bit 7 = 0 means write. Bits 6:0 give the start address. The address increments after every data byte and wraps from 127 to 0.
- R4: A write to an address below NREG stores the byte. A write to address NREG or above changes nothing. A read from such an address returns 00h.
- R5: Register 0 bit 6 sets the order of every byte on the wire, instruction included: 0 means MSB first and 1 means LSB first. A new order applies from the byte after the one that wrote it.
- R6: When register 0 bit 7 is 0, read data appears on `sdo` with `sdo_oe`=1 and `sdio_oe`=0. When bit 7 is 1, read data appears on `sdio_out` with `sdio_oe`=1 and `sdo_oe`=0. Outside the data phase of a read, both enables are 0.
- R7: Writing a byte with bit 5 set to register 0 clears registers 1 to NREG-1 to 00h. Register 0 takes the other bits of that byte.
- R8: Register 0 bit 5 always reads back as 0.
- R9: `rst` clears every register, register 0 included, and deasserts both output enables.
- R10: `regs_flat[8*i+7:8*i]` always equals register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high hardware reset |
| csn | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Input side of the bidirectional data pin |
| sdio_out | output | 1 | Output side of the bidirectional data pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional data pin |
| sdo | output | 1 | Dedicated serial data output |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 means high impedance) |
| regs_flat | output | NREG*8 | All registers, register i at bits 8*i+7:8*i |

## Verification
The bench aims at the byte boundary where register 0 changes bit order or pin direction in the middle of a burst. A design that latched the old setting would scramble the next byte. It also covers address wrap from 127 into register 0, and out-of-range reads that must return zero. Another target is a soft reset that must spare register 0 yet leave its own bit clear; a design that got this wrong would wipe the configuration or leave the bit stuck. Chip select is also dropped in the middle of an instruction and in the middle of a data byte. A port that kept its bit count would shift every later byte, and one that committed a partial byte would corrupt a register. Read bits are sampled both before and after the rising edge, which exposes any design that launches on the wrong edge.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int CFG_DIR   = 7;
    localparam int CFG_ORDER = 6;
    localparam int CFG_SRST  = 5;

    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // Append one received bit according to the configured wire order.
    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                   input logic b,
                                                   input logic lsb_first);
        return lsb_first ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    // Bit that leaves the shifter next.
    function automatic logic head_bit(input logic [BYTE_W-1:0] v, input logic lsb_first);
        return lsb_first ? v[0] : v[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] drop_head(input logic [BYTE_W-1:0] v,
                                                    input logic lsb_first);
        return lsb_first ? {1'b0, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/spireg_edge.sv
module spireg_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

    // R1: a detected rising edge is never reported twice in a row
    a_r1_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/spireg_shifter.sv
module spireg_shifter
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              tx_en,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              dout
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign rx_byte   = shift_in(rx_sh, din, lsb_first);
    assign byte_done = active && rise && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
            dout  <= 1'b0;
        end else begin
            if (rise) begin
                cnt   <= cnt + 1'b1;
                rx_sh <= rx_byte;
            end
            if (load) begin
                tx_sh <= load_val;
            end else if (fall && tx_en) begin
                dout  <= head_bit(tx_sh, lsb_first);
                tx_sh <= drop_head(tx_sh, lsb_first);
            end
        end
    end

    // R1: serial output moves only in response to a falling edge
    a_r1_launch_on_fall: assert property (@(posedge clk) disable iff (rst)
        (active && !fall) |=> $stable(dout));

    // R2: leaving the selected state always restarts the bit count
    a_r2_count_restart: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));

endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
    import spireg_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [BYTE_W-1:0]      wdata,
    input  logic [ADDR_W-1:0]      raddr,
    output logic [BYTE_W-1:0]      rdata,
    output logic [BYTE_W-1:0]      cfg,
    output logic [NREG*BYTE_W-1:0] flat
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);
    localparam logic [BYTE_W-1:0] SRST_MASK = BYTE_W'(1) << CFG_SRST;

    logic [BYTE_W-1:0] regs [NREG];
    logic              w_hit;

    assign w_hit = we && (waddr < NREG_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (w_hit) begin
            if (waddr == '0) begin
                regs[0] <= wdata & ~SRST_MASK;
                if (wdata[CFG_SRST]) begin
                    for (int i = 1; i < NREG; i++) regs[i] <= '0;
                end
            end else begin
                regs[waddr[IDX_W-1:0]] <= wdata;
            end
        end
    end

    assign rdata = (raddr < NREG_A) ? regs[raddr[IDX_W-1:0]] : '0;
    assign cfg   = regs[0];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat[g*BYTE_W +: BYTE_W] = regs[g];
    end

    // R7: a soft reset request leaves the top register cleared
    a_r7_srst_clears: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0 && wdata[CFG_SRST]) |=> (regs[NREG-1] == '0));

    // R8: the soft reset bit never stays set
    a_r8_srst_self_clear: assert property (@(posedge clk) disable iff (rst)
        we |=> !cfg[CFG_SRST]);

    // R4: writes outside the bank leave every register untouched
    a_r4_oob_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && waddr >= NREG_A) |=> $stable(flat));

    // R9: hardware reset empties the whole bank
    a_r9_hw_reset: assert property (@(posedge clk)
        rst |=> (flat == '0));

endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
    import spireg_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   csn,
    input  logic                   sclk,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    logic              active;
    logic              rise, fall;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              dout;
    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    cmd_t              cmd;
    logic [BYTE_W-1:0] cfg;
    logic [BYTE_W-1:0] rdata;
    logic [ADDR_W-1:0] raddr;
    logic              load;
    logic              we;
    logic              reading;

    assign active = ~csn;
    assign cmd    = cmd_t'(rx_byte);

    spireg_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    spireg_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .rise      (rise),
        .fall      (fall),
        .din       (sdio_in),
        .lsb_first (cfg[CFG_ORDER]),
        .load      (load),
        .load_val  (rdata),
        .tx_en     (phase == PH_RD),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .dout      (dout)
    );

    spireg_bank #(.NREG(NREG)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (addr),
        .wdata (rx_byte),
        .raddr (raddr),
        .rdata (rdata),
        .cfg   (cfg),
        .flat  (regs_flat)
    );

    // Read source: the start address right after the instruction, else the next one.
    assign raddr = (phase == PH_CMD) ? cmd.addr : addr + 1'b1;
    assign load  = byte_done && ((phase == PH_CMD && cmd.rd) || phase == PH_RD);
    assign we    = byte_done && (phase == PH_WR);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase <= PH_CMD;
            addr  <= '0;
        end else if (byte_done) begin
            case (phase)
                PH_CMD: begin
                    addr  <= cmd.addr;
                    phase <= cmd.rd ? PH_RD : PH_WR;
                end
                default: addr <= addr + 1'b1;
            endcase
        end
    end

    assign reading  = active && (phase == PH_RD);
    assign sdio_out = dout;
    assign sdo      = dout;
    assign sdio_oe  = reading && cfg[CFG_DIR];
    assign sdo_oe   = reading && !cfg[CFG_DIR];

    // R6: never both pins driving
    a_r6_one_driver: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    // R6: deselected port drives nothing
    a_r6_idle_hiz: assert property (@(posedge clk) disable iff (rst)
        csn |-> !(sdio_oe || sdo_oe));

    // R2: deselect returns the port to the instruction phase
    a_r2_cs_restarts: assert property (@(posedge clk) disable iff (rst)
        csn |=> (phase == PH_CMD));

    // R3: each data byte advances the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase != PH_CMD) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: tb/spi_ctrl_port_test.sv
module spi_ctrl_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo, sdo_oe;
    logic [NREG*8-1:0] regs_flat;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m [NREG];
    logic [7:0] wbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ctrl_port #(.NREG(NREG)) uut (
        .clk(clk), .rst(rst), .csn(csn), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .regs_flat(regs_flat)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected effect of a data byte write, from R4, R7, R8.
    task automatic model_write(input logic [6:0] a, input logic [7:0] v);
        if (a < NREG) begin
            if (a == 0) begin
                if (v[5]) for (int i = 1; i < NREG; i++) m[i] = 8'h00;
                m[0] = v & 8'hDF;
            end else begin
                m[a] = v;
            end
        end
    endtask

    task automatic check_flat(input string tag);
        for (int i = 0; i < NREG; i++)
            check(regs_flat[i*8 +: 8] === m[i], tag, 32'(regs_flat[i*8 +: 8]), 32'(m[i]));
    endtask

    // One byte (or its first nb bits) on the wire, order and pin from the model of reg 0.
    task automatic spi_byte(input logic [7:0] tx, input bit rd_phase, input int nb,
                            output logic [7:0] rx);
        bit lsb, dir;
        lsb = m[0][6];
        dir = m[0][7];
        rx = 8'h00;
        for (int i = 0; i < nb; i++) begin
            int k;
            logic b;
            k = lsb ? i : 7 - i;
            sclk = 1'b0;
            sdio_in = tx[k];
            repeat (4) @(negedge clk);
            if (rd_phase) begin
                b = dir ? sdio_out : sdo;
                rx[k] = b;
                check(dir ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe), "R6 read enables",
                      {30'd0, sdio_oe, sdo_oe}, dir ? 32'd2 : 32'd1);
            end else begin
                b = 1'b0;
                check(!sdio_oe && !sdo_oe, "R6 idle enables", {30'd0, sdio_oe, sdo_oe}, 32'd0);
            end
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            if (rd_phase)
                check((dir ? sdio_out : sdo) === b, "R1 hold across rise",
                      32'(dir ? sdio_out : sdo), 32'(b));
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic xfer(input bit rd, input logic [6:0] addr, input int n);
        logic [7:0] rx;
        logic [7:0] exp;
        logic [6:0] cur;
        csn = 1'b0;
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        spi_byte({rd, addr}, 1'b0, 8, rx);
        cur = addr;
        for (int j = 0; j < n; j++) begin
            if (rd) begin
                spi_byte(8'h00, 1'b1, 8, rx);
                exp = (cur < NREG) ? m[cur] : 8'h00;
                check(rx === exp, "R3/R4 read data", 32'(rx), 32'(exp));
            end else begin
                spi_byte(wbuf[j], 1'b0, 8, rx);
                model_write(cur, wbuf[j]);
            end
            cur = cur + 7'd1;
        end
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        csn = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic partial(input logic [7:0] tx, input int nb);
        logic [7:0] rx;
        csn = 1'b0;
        repeat (2) @(negedge clk);
        spi_byte(tx, 1'b0, nb, rx);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        csn = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rx;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NREG; i++) m[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check(regs_flat === '0, "R9 reset bank", 32'(regs_flat), 32'd0);
        check(!sdio_oe && !sdo_oe, "R9 reset enables", {30'd0, sdio_oe, sdo_oe}, 32'd0);

        // R3, R4, R10: MSB-first burst write then read back
        wbuf[0] = 8'h11; wbuf[1] = 8'hA2; wbuf[2] = 8'h3C;
        xfer(1'b0, 7'd1, 3);
        check_flat("R10 flat after burst");
        xfer(1'b1, 7'd1, 3);

        // R3: wrap from 127 into register 0 (127 is outside the bank: R4)
        wbuf[0] = 8'hEE; wbuf[1] = 8'h1F;
        xfer(1'b0, 7'd127, 2);
        check(regs_flat[7:0] === 8'h1F, "R3 wrap to reg0", 32'(regs_flat[7:0]), 32'h1F);

        // R4: out-of-range read returns zero
        xfer(1'b1, 7'd20, 2);

        // R5: switch to LSB first mid-burst; next byte uses new order
        wbuf[0] = 8'h40; wbuf[1] = 8'hA5;
        xfer(1'b0, 7'd0, 2);
        check(regs_flat[15:8] === 8'hA5, "R5 byte after order change", 32'(regs_flat[15:8]), 32'hA5);
        xfer(1'b1, 7'd0, 4);

        // R6: 3-wire reads on the bidirectional pin
        wbuf[0] = 8'hC0;
        xfer(1'b0, 7'd0, 1);
        xfer(1'b1, 7'd1, 3);
        wbuf[0] = 8'h00;
        xfer(1'b0, 7'd0, 1);

        // Random mix of transfers, checked against the model
        for (int t = 0; t < 50; t++) begin
            bit rd;
            logic [6:0] a;
            int n;
            rd = 1'($urandom_range(1, 0));
            a  = 7'($urandom_range(NREG + 2, 0));
            if ($urandom_range(9, 0) == 0) a = 7'd126;
            n  = int'($urandom_range(4, 1));
            for (int j = 0; j < 8; j++) wbuf[j] = 8'($urandom());
            xfer(rd, a, n);
            check_flat("R10 random flat");
        end

        // R7, R8: soft reset keeps reg0, clears the rest
        wbuf[0] = 8'h00;
        xfer(1'b0, 7'd0, 1);
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
        xfer(1'b0, 7'd1, 3);
        wbuf[0] = 8'hA5;
        xfer(1'b0, 7'd0, 1);
        check(regs_flat[7:0] === 8'h85, "R8 reg0 after soft reset", 32'(regs_flat[7:0]), 32'h85);
        check(regs_flat[NREG*8-1:8] === '0, "R7 others cleared", 32'(regs_flat[31:8]), 32'd0);
        xfer(1'b1, 7'd0, 2);

        // R2: chip select dropped mid instruction and mid data byte
        wbuf[0] = 8'h00;
        xfer(1'b0, 7'd0, 1);
        wbuf[0] = 8'h44;
        xfer(1'b0, 7'd3, 1);
        partial(8'h83, 4);
        wbuf[0] = 8'h3C;
        xfer(1'b0, 7'd2, 1);
        check(regs_flat[23:16] === 8'h3C, "R2 instruction after abort", 32'(regs_flat[23:16]), 32'h3C);
        csn = 1'b0;
        repeat (2) @(negedge clk);
        spi_byte(8'h03, 1'b0, 8, rx);
        spi_byte(8'hFF, 1'b0, 5, rx);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        csn = 1'b1;
        repeat (3) @(negedge clk);
        check(regs_flat[31:24] === 8'h44, "R2 partial data dropped", 32'(regs_flat[31:24]), 32'h44);
        check_flat("R2 bank intact");

        // R9: hardware reset clears reg0 too
        wbuf[0] = 8'hC3;
        xfer(1'b0, 7'd0, 1);
        wbuf[0] = 8'h77;
        xfer(1'b0, 7'd4, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NREG; i++) m[i] = 8'h00;
        check(regs_flat === '0, "R9 hw reset bank", 32'(regs_flat), 32'd0);
        xfer(1'b1, 7'd0, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule